// File: doc/BRIEF.md
# Accumulator ALU with flags

This block is the purely combinational arithmetic and logic unit of a small accumulator datapath. The accumulator A always sits on the left side of every operation. The right-hand operand arrives already selected by the surrounding datapath, whether it came from a register, an immediate field or a memory read. A 4-bit function code picks one of nine operations. The block returns a 16-bit result, a write strobe for the accumulator, the Zero, Negative and Carry flag values, and a separate update enable for each of the four flags.

Compare runs the same subtraction as subtract but reports only flags, so the accumulator keeps its value. Shift left, shift right and byte swap act on the right-hand operand and place the result in A. None of the operations touches the Overflow flag. Any function code outside the nine defined ones is inert: the block raises no strobe and no flag enable.

The style's "states" are the function codes, held in the package enumeration. IDLE covers code 0 and codes 10 to 15, and the named codes are ADD=1, SUB=2, CMP=3, AND=4, OR=5, XOR=6, SHL=7, SHR=8 and SWAP=9. There are no transitions: each evaluation depends only on the present inputs.

Top module: `acc_alu`

## Requirements
- R1: Function code 1 (add) gives result = (A + B) mod 2^16. Carry is the carry out of bit 15, and the accumulator write strobe is 1.
- R2: Function code 2 (subtract) gives result = (A - B) mod 2^16. Carry is 1 exactly when B > A as unsigned values (a borrow), and the write strobe is 1.
- R3: Function code 3 (compare) produces the same result value and flags as subtract, but the accumulator write strobe is 0.
- R4: Function codes 4, 5 and 6 give the bitwise AND, OR and XOR of A and B. Carry is 0 and the write strobe is 1.
- R5: Function code 7 (shift left) gives result = B shifted left by one with bit 0 filled with 0. Carry equals bit 15 of B, and the write strobe is 1.
- R6: Function code 8 (shift right) gives result = B shifted right by one with bit 15 filled with 0. Carry equals bit 0 of B, and the write strobe is 1.
- R7: Function code 9 (swap) gives result[15:8] = B[7:0] and result[7:0] = B[15:8]. Carry is 0 and the write strobe is 1.
- R8: For every defined code (1 to 9), Zero is 1 exactly when the 16-bit result is 0, and Negative equals bit 15 of the result.
- R9: For every defined code, the Zero, Negative and Carry update enables are all 1. The Overflow update enable is 0 for every code.
- R10: Function code 0 and codes 10 to 15 drive result 0, write strobe 0, all flag values 0 and all flag update enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| func_i | input | 4 | Operation select code |
| acc_i | input | 16 | Accumulator value, left operand |
| opnd_i | input | 16 | Right-hand operand |
| result_o | output | 16 | Operation result |
| acc_we_o | output | 1 | Write strobe for the accumulator |
| flag_z_o | output | 1 | Zero flag value |
| flag_n_o | output | 1 | Negative flag value |
| flag_c_o | output | 1 | Carry flag value |
| flag_z_we_o | output | 1 | Zero flag update enable |
| flag_n_we_o | output | 1 | Negative flag update enable |
| flag_c_we_o | output | 1 | Carry flag update enable |
| flag_v_we_o | output | 1 | Overflow flag update enable |

## Verification
The assertions check a set of rules whenever the inputs change. The Zero and Negative values must agree with the result. Defined codes must raise all three flag enables, and the Overflow enable must stay low. Compare must never write the accumulator, undefined codes must stay inert, and the add sum with carry must equal the arithmetic total.

Only the bench scenarios can show that each operation produces the right value and carry. These cover the borrow on subtract, which bit is shifted into Carry, and which bytes the swap exchanges. The bench compares these against its own model over random operands and directed edge values, such as all-ones plus one, zero minus one, equal compare, and the top or bottom bit shifted out.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        FN_IDLE = 4'd0,
        FN_ADD  = 4'd1,
        FN_SUB  = 4'd2,
        FN_CMP  = 4'd3,
        FN_AND  = 4'd4,
        FN_OR   = 4'd5,
        FN_XOR  = 4'd6,
        FN_SHL  = 4'd7,
        FN_SHR  = 4'd8,
        FN_SWAP = 4'd9
    } alu_fn_e;

    typedef enum logic [1:0] {
        GRP_NONE  = 2'd0,
        GRP_ARITH = 2'd1,
        GRP_LOGIC = 2'd2,
        GRP_MOVE  = 2'd3
    } alu_grp_e;

    function automatic alu_grp_e fn_group(input logic [3:0] code);
        alu_grp_e g;
        unique case (code)
            4'd1, 4'd2, 4'd3: g = GRP_ARITH;
            4'd4, 4'd5, 4'd6: g = GRP_LOGIC;
            4'd7, 4'd8, 4'd9: g = GRP_MOVE;
            default:          g = GRP_NONE;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         sub_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o,
    output logic         c_o
);
    localparam int XW = W + 1;

    logic [XW-1:0] wide_sum;
    logic [XW-1:0] wide_diff;

    always_comb begin
        wide_sum  = {1'b0, a_i} + {1'b0, b_i};
        wide_diff = {1'b0, a_i} - {1'b0, b_i};
        if (sub_i) begin
            y_o = wide_diff[W-1:0];
            c_o = wide_diff[W];
        end else begin
            y_o = wide_sum[W-1:0];
            c_o = wide_sum[W];
        end
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   fn_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        case (fn_i)
            FN_AND:  y_o = a_i & b_i;
            FN_OR:   y_o = a_i | b_i;
            FN_XOR:  y_o = a_i ^ b_i;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/acc_alu_move.sv
module acc_alu_move
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   fn_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o,
    output logic         c_o
);
    localparam int HW = W / 2;

    logic [W-1:0] swapped;

    genvar k;
    generate
        for (k = 0; k < HW; k++) begin : g_lane
            assign swapped[k]      = b_i[k + HW];
            assign swapped[k + HW] = b_i[k];
        end
    endgenerate

    always_comb begin
        case (fn_i)
            FN_SHL: begin
                y_o = {b_i[W-2:0], 1'b0};
                c_o = b_i[W-1];
            end
            FN_SHR: begin
                y_o = {1'b0, b_i[W-1:1]};
                c_o = b_i[0];
            end
            FN_SWAP: begin
                y_o = swapped;
                c_o = 1'b0;
            end
            default: begin
                y_o = '0;
                c_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags #(
    parameter int W = 16
) (
    input  logic         valid_i,
    input  logic [W-1:0] y_i,
    input  logic         c_i,
    output logic         z_o,
    output logic         n_o,
    output logic         c_o,
    output logic         upd_o
);
    always_comb begin
        upd_o = valid_i;
        z_o   = valid_i & (y_i == '0);
        n_o   = valid_i & y_i[W-1];
        c_o   = valid_i & c_i;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   func_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    output logic [W-1:0] result_o,
    output logic         acc_we_o,
    output logic         flag_z_o,
    output logic         flag_n_o,
    output logic         flag_c_o,
    output logic         flag_z_we_o,
    output logic         flag_n_we_o,
    output logic         flag_c_we_o,
    output logic         flag_v_we_o
);
    alu_grp_e     grp;
    logic         is_sub;
    logic [W-1:0] arith_y;
    logic         arith_c;
    logic [W-1:0] logic_y;
    logic [W-1:0] move_y;
    logic         move_c;
    logic [W-1:0] sel_y;
    logic         sel_c;
    logic         valid;
    logic         upd;

    assign grp    = fn_group(func_i);
    assign is_sub = (func_i == FN_SUB) || (func_i == FN_CMP);

    acc_alu_arith #(.W(W)) u_arith (
        .sub_i (is_sub),
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .y_o   (arith_y),
        .c_o   (arith_c)
    );

    acc_alu_logic #(.W(W)) u_logic (
        .fn_i  (func_i),
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .y_o   (logic_y)
    );

    acc_alu_move #(.W(W)) u_move (
        .fn_i  (func_i),
        .b_i   (opnd_i),
        .y_o   (move_y),
        .c_o   (move_c)
    );

    always_comb begin
        unique case (grp)
            GRP_ARITH: begin sel_y = arith_y; sel_c = arith_c; valid = 1'b1; end
            GRP_LOGIC: begin sel_y = logic_y; sel_c = 1'b0;    valid = 1'b1; end
            GRP_MOVE:  begin sel_y = move_y;  sel_c = move_c;  valid = 1'b1; end
            default:   begin sel_y = '0;      sel_c = 1'b0;    valid = 1'b0; end
        endcase
    end

    acc_alu_flags #(.W(W)) u_flags (
        .valid_i (valid),
        .y_i     (sel_y),
        .c_i     (sel_c),
        .z_o     (flag_z_o),
        .n_o     (flag_n_o),
        .c_o     (flag_c_o),
        .upd_o   (upd)
    );

    always_comb begin
        result_o    = sel_y;
        acc_we_o    = valid && (func_i != FN_CMP);
        flag_z_we_o = upd;
        flag_n_we_o = upd;
        flag_c_we_o = upd;
        flag_v_we_o = 1'b0;
    end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int W = 16
) (
    input logic [3:0]   func_i,
    input logic [W-1:0] acc_i,
    input logic [W-1:0] opnd_i,
    input logic [W-1:0] result_o,
    input logic         acc_we_o,
    input logic         flag_z_o,
    input logic         flag_n_o,
    input logic         flag_c_o,
    input logic         flag_z_we_o,
    input logic         flag_n_we_o,
    input logic         flag_c_we_o,
    input logic         flag_v_we_o
);
    logic known;
    logic defined;
    logic [W:0] total;

    always_comb begin
        known   = !$isunknown({func_i, acc_i, opnd_i});
        defined = (func_i >= 4'd1) && (func_i <= 4'd9);
        total   = {1'b0, acc_i} + {1'b0, opnd_i};
    end

    always_comb begin
        if (known) begin
            assert_zero_flag_R8: assert (!defined || (flag_z_o == (result_o == '0)))
                else $error("zero flag disagrees with result");
            assert_neg_flag_R8: assert (!defined || (flag_n_o == result_o[W-1]))
                else $error("negative flag disagrees with result");
            assert_enables_R9: assert (!defined || (flag_z_we_o && flag_n_we_o && flag_c_we_o))
                else $error("flag enables low on defined code");
            assert_no_overflow_R9: assert (!flag_v_we_o)
                else $error("overflow enable raised");
            assert_cmp_nowrite_R3: assert ((func_i != 4'd3) || !acc_we_o)
                else $error("compare wrote accumulator");
            assert_idle_R10: assert (defined ||
                    (!acc_we_o && !flag_z_we_o && !flag_n_we_o && !flag_c_we_o && result_o == '0))
                else $error("undefined code not inert");
            assert_add_sum_R1: assert ((func_i != 4'd1) || ({flag_c_o, result_o} == total))
                else $error("add sum mismatch");
        end
    end
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
    .func_i      (func_i),
    .acc_i       (acc_i),
    .opnd_i      (opnd_i),
    .result_o    (result_o),
    .acc_we_o    (acc_we_o),
    .flag_z_o    (flag_z_o),
    .flag_n_o    (flag_n_o),
    .flag_c_o    (flag_c_o),
    .flag_z_we_o (flag_z_we_o),
    .flag_n_we_o (flag_n_we_o),
    .flag_c_we_o (flag_c_we_o),
    .flag_v_we_o (flag_v_we_o)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
    logic        clk = 1'b0;
    logic [3:0]  func;
    logic [15:0] acc;
    logic [15:0] opnd;
    logic [15:0] result;
    logic        acc_we, fz, fn, fc, zwe, nwe, cwe, vwe;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    acc_alu u_acc_alu (
        .func_i (func), .acc_i (acc), .opnd_i (opnd),
        .result_o (result), .acc_we_o (acc_we),
        .flag_z_o (fz), .flag_n_o (fn), .flag_c_o (fc),
        .flag_z_we_o (zwe), .flag_n_we_o (nwe), .flag_c_we_o (cwe),
        .flag_v_we_o (vwe)
    );

    function automatic string tag_of(input logic [3:0] f);
        case (f)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4, 4'd5, 4'd6: return "R4";
            4'd7: return "R5";
            4'd8: return "R6";
            4'd9: return "R7";
            default: return "R10";
        endcase
    endfunction

    // Expected packed as {result, we, z, n, c, zwe, nwe, cwe, vwe}
    function automatic logic [23:0] model(input logic [3:0] f, input logic [15:0] a, input logic [15:0] b);
        logic [16:0] t;
        logic [15:0] y;
        logic c, we, ok;
        ok = 1'b1; we = 1'b1; c = 1'b0; y = 16'h0;
        case (f)
            4'd1: begin t = a + b; y = t[15:0]; c = t[16]; end
            4'd2: begin y = a - b; c = (b > a); end
            4'd3: begin y = a - b; c = (b > a); we = 1'b0; end
            4'd4: y = a & b;
            4'd5: y = a | b;
            4'd6: y = a ^ b;
            4'd7: begin y = b << 1; c = b[15]; end
            4'd8: begin y = b >> 1; c = b[0]; end
            4'd9: y = {b[7:0], b[15:8]};
            default: begin ok = 1'b0; we = 1'b0; end
        endcase
        return {y, we, ok && (y == 16'h0), ok && y[15], c, ok, ok, ok, 1'b0};
    endfunction

    task automatic apply(input logic [3:0] f, input logic [15:0] a, input logic [15:0] b);
        logic [23:0] exp_v, act_v;
        @(negedge clk);
        func = f; acc = a; opnd = b;
        #1;
        exp_v = model(f, a, b);
        act_v = {result, acc_we, fz, fn, fc, zwe, nwe, cwe, vwe};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s (flags R8/R9) func=%0d a=%h b=%h actual=%h expected=%h",
                     tag_of(f), f, a, b, act_v, exp_v);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 200000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<200000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        func = 4'd0; acc = 16'h0; opnd = 16'h0;
        apply(4'd0, 16'h0000, 16'h0000);          // R10 initial idle state
        apply(4'd1, 16'hFFFF, 16'h0001);          // R1 wrap to zero, carry
        apply(4'd1, 16'h7FFF, 16'h0001);          // R1 negative, no carry
        apply(4'd2, 16'h0000, 16'h0001);          // R2 borrow
        apply(4'd2, 16'h1234, 16'h1234);          // R2 zero, no borrow
        apply(4'd3, 16'h5555, 16'h5555);          // R3 equal compare
        apply(4'd3, 16'h0001, 16'h0002);          // R3 borrow, no write
        apply(4'd4, 16'hF0F0, 16'h0F0F);          // R4 and to zero
        apply(4'd5, 16'h8000, 16'h0001);          // R4 or
        apply(4'd6, 16'hAAAA, 16'hAAAA);          // R4 xor zero
        apply(4'd7, 16'hFFFF, 16'h8000);          // R5 bit 15 out
        apply(4'd7, 16'h0000, 16'h4001);          // R5 into sign
        apply(4'd8, 16'hFFFF, 16'h0001);          // R6 bit 0 out
        apply(4'd8, 16'h0000, 16'h8000);          // R6 zero fill
        apply(4'd9, 16'h0000, 16'h12AB);          // R7 swap, negative
        apply(4'd9, 16'hFFFF, 16'h0000);          // R7 zero
        for (int f = 10; f < 16; f++)
            apply(4'(f), 16'hFFFF, 16'hFFFF);     // R10 undefined codes
        for (int i = 0; i < 3000; i++)
            apply(4'($urandom_range(0, 15)), 16'($urandom), 16'($urandom));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule